// File: doc/BRIEF.md
# Priority Interrupt Controller

This block gathers interrupt request lines from a set of devices, folds them into one request to the processor, and names the device to serve. Arbitration has two modes, chosen by a mode pin. In the fixed-scan mode every raised request is a candidate, and the candidate with the lowest index wins. In the nesting mode a device counts only if its priority level is strictly greater than the processor's current priority. Requests that fail this test stay pending and take no part until the processor priority falls.

When the processor answers with a rising edge on its acknowledge line, the controller freezes the winner. It then pulses that device's own acknowledge line for one cycle so the device can drop its request. In the same cycle it offers the device's vector code, equal to a base value plus the device index, on a valid/ready output. The vector and its valid flag hold until the processor accepts them. While a vector is outstanding, further acknowledge edges are ignored, so an unread vector is never overwritten.

Top module: `prio_intc`

## Requirements
- R1: `intr` is high exactly when `ien` is 1 and at least one request is eligible. With `ien` at 0, `intr` stays low whatever the requests are.
- R2: With `arb_mode` = 0 (fixed scan), every raised request is eligible whatever `cpu_prio` holds, and the eligible device with the lowest index wins.
- R3: With `arb_mode` = 1 (nesting), device i has level N_DEV − i. It is eligible only when its request is raised and its level is strictly greater than `cpu_prio`. The winner is the lowest eligible index.
- R4: The winner is captured at the first clock edge where `inta` is 1 after being 0 at the previous edge. Holding `inta` high captures nothing more.
- R5: Capture drives `ack` in the next cycle with exactly one bit set, the winner's bit, for one cycle only. Otherwise `ack` is zero.
- R6: Capture raises `vec_valid` in the same cycle as the `ack` pulse, with `vec` = VEC_BASE + winner index.
- R7: `vec_valid` and `vec` hold steady until an edge where `vec_ready` is 1, and `vec_valid` is low after that edge. An `inta` rising edge that arrives while `vec_valid` is high is ignored, including one in the handshake cycle.
- R8: An `inta` rising edge with no eligible request, or with `ien` at 0, produces no `ack` and no `vec_valid`.
- R9: After reset, `ack` is zero and `vec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N_DEV | Device request lines, index 0 highest |
| ien | input | 1 | Interrupt enable; 0 masks everything |
| arb_mode | input | 1 | 0 fixed scan, 1 nesting |
| cpu_prio | input | PRIO_W | Current processor priority level |
| intr | output | 1 | Combined request to the processor |
| inta | input | 1 | Processor acknowledge; rising edge captures the winner |
| ack | output | N_DEV | Per-device one-cycle acknowledge |
| vec | output | VEC_W | Vector code of the captured device |
| vec_valid | output | 1 | Vector offered |
| vec_ready | input | 1 | Processor takes the vector |

## Verification
Two things can land on one clock edge: a new `inta` rising edge, and the completion of the vector handshake (`vec_ready` high while `vec_valid` is high). The bench raises `inta` once while a vector is still waiting and once in the exact cycle `vec_ready` is asserted. In both cases it expects no `ack` pulse and no new vector: `vec_valid` must stay high with the old code until the handshake, and be low after it. A sweep over every request pattern, both modes and every processor level compares `intr`, the `ack` bit and the vector against values computed in the bench.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  typedef enum logic {
    ARB_SCAN = 1'b0,
    ARB_NEST = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/prio_intc_filter.sv
// Eligibility mask: scan mode passes all requests, nesting mode passes a
// device only when its level N_DEV-i is strictly above the processor level.
module prio_intc_filter #(
  parameter int N_DEV  = 8,
  parameter int PRIO_W = 4
) (
  input  logic [N_DEV-1:0]  req,
  input  logic              nest,
  input  logic [PRIO_W-1:0] cpu_prio,
  output logic [N_DEV-1:0]  elig
);
  for (genvar i = 0; i < N_DEV; i++) begin : g_lvl
    localparam logic [PRIO_W-1:0] LVL = PRIO_W'(N_DEV - i);
    assign elig[i] = req[i] & (~nest | (LVL > cpu_prio));
  end
endmodule

// File: rtl/prio_intc_pick.sv
// Lowest set index wins.
module prio_intc_pick #(
  parameter int N_DEV = 8,
  localparam int IDX_W = $clog2(N_DEV)
) (
  input  logic [N_DEV-1:0] elig,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N_DEV - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/prio_intc_vecout.sv
// Vector output stage: loads on capture, holds until taken.
module prio_intc_vecout #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [VEC_W-1:0] load_vec,
  input  logic             vec_ready,
  output logic [VEC_W-1:0] vec,
  output logic             vec_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec       <= '0;
    end else if (load) begin
      vec_valid <= 1'b1;
      vec       <= load_vec;
    end else if (vec_ready) begin
      vec_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int N_DEV    = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 32,
  localparam int PRIO_W  = $clog2(N_DEV + 1),
  localparam int IDX_W   = $clog2(N_DEV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_DEV-1:0]  req,
  input  logic              ien,
  input  logic              arb_mode,
  input  logic [PRIO_W-1:0] cpu_prio,
  output logic              intr,
  input  logic              inta,
  output logic [N_DEV-1:0]  ack,
  output logic [VEC_W-1:0]  vec,
  output logic              vec_valid,
  input  logic              vec_ready
);
  import prio_intc_pkg::*;

  arb_mode_e        mode;
  logic [N_DEV-1:0] elig;
  logic             found;
  logic [IDX_W-1:0] win_idx;
  logic             inta_q;
  logic             capture;

  assign mode = arb_mode_e'(arb_mode);

  prio_intc_filter #(.N_DEV(N_DEV), .PRIO_W(PRIO_W)) u_filter (
    .req      (req),
    .nest     (mode == ARB_NEST),
    .cpu_prio (cpu_prio),
    .elig     (elig)
  );

  prio_intc_pick #(.N_DEV(N_DEV)) u_pick (
    .elig  (elig),
    .found (found),
    .idx   (win_idx)
  );

  assign intr    = ien & found;
  assign capture = inta & ~inta_q & intr & ~vec_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inta_q <= 1'b0;
      ack    <= '0;
    end else begin
      inta_q <= inta;
      ack    <= capture ? (N_DEV'(1) << win_idx) : '0;
    end
  end

  prio_intc_vecout #(.VEC_W(VEC_W)) u_vecout (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (capture),
    .load_vec  (VEC_W'(VEC_BASE) + VEC_W'(win_idx)),
    .vec_ready (vec_ready),
    .vec       (vec),
    .vec_valid (vec_valid)
  );
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int N_DEV = 8,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ien,
  input logic             intr,
  input logic [N_DEV-1:0] ack,
  input logic [VEC_W-1:0] vec,
  input logic             vec_valid,
  input logic             vec_ready
);
  assert_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !intr);

  assert_ack_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack));

  assert_ack_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack != '0) |=> (ack == '0));

  assert_ack_with_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack != '0) |-> $rose(vec_valid));

  assert_vec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec)));

  assert_vec_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ready) |=> !vec_valid);
endmodule

bind prio_intc prio_intc_chk #(.N_DEV(N_DEV), .VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ien       (ien),
  .intr      (intr),
  .ack       (ack),
  .vec       (vec),
  .vec_valid (vec_valid),
  .vec_ready (vec_ready)
);

// File: tb/test_prio_intc.sv
module test_prio_intc;
  localparam int ND   = 4;
  localparam int BASE = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic       ien = 1'b0;
  logic       arb_mode = 1'b0;
  logic [2:0] cpu_prio = '0;
  logic       intr;
  logic       inta = 1'b0;
  logic [3:0] ack;
  logic [7:0] vec;
  logic       vec_valid;
  logic       vec_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prio_intc #(.N_DEV(ND), .VEC_W(8), .VEC_BASE(BASE)) i_prio_intc (
    .clk(clk), .rst_n(rst_n), .req(req), .ien(ien), .arb_mode(arb_mode),
    .cpu_prio(cpu_prio), .intr(intr), .inta(inta), .ack(ack), .vec(vec),
    .vec_valid(vec_valid), .vec_ready(vec_ready)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected winner: -1 when none eligible (R2 scan, R3 nesting level ND-i).
  function automatic int model_win(input logic [3:0] r, input logic m, input int p);
    for (int i = 0; i < ND; i++)
      if (r[i] && (!m || (ND - i) > p)) return i;
    return -1;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 ack after reset", int'(ack), 0);
    chk("R9 vec_valid after reset", int'(vec_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep: all request patterns, both modes, every processor level.
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p <= ND; p++) begin
        for (int r = 0; r < 16; r++) begin
          int w;
          string tg;
          tg = (m == 0) ? "R2" : "R3";
          w = model_win(4'(r), m[0], p);
          req = 4'(r); arb_mode = m[0]; cpu_prio = 3'(p);
          ien = 1'b0;
          #1;
          chk("R1 intr masked", int'(intr), 0);
          // edge with ien low captures nothing (R8)
          inta = 1'b1;
          @(negedge clk);
          chk("R8 no ack when masked", int'(ack), 0);
          chk("R8 no vec when masked", int'(vec_valid), 0);
          inta = 1'b0;
          ien = 1'b1;
          @(negedge clk);
          chk({tg, " R1 intr"}, int'(intr), (w >= 0) ? 1 : 0);
          inta = 1'b1;
          @(negedge clk);
          chk({tg, " R5 ack bit"}, int'(ack), (w >= 0) ? (1 << w) : 0);
          chk("R6 R8 vec_valid", int'(vec_valid), (w >= 0) ? 1 : 0);
          if (w >= 0) chk("R6 vector", int'(vec), BASE + w);
          // inta held high: no second capture, vector holds (R4 R5 R7)
          @(negedge clk);
          chk("R4 R5 ack single", int'(ack), 0);
          chk("R7 vec_valid held", int'(vec_valid), (w >= 0) ? 1 : 0);
          if (w >= 0) chk("R7 vector held", int'(vec), BASE + w);
          vec_ready = 1'b1;
          @(negedge clk);
          vec_ready = 1'b0;
          chk("R7 vec taken", int'(vec_valid), 0);
          @(negedge clk);
          chk("R4 no recapture while high", int'(ack), 0);
          chk("R4 no new vector", int'(vec_valid), 0);
          inta = 1'b0;
          @(negedge clk);
        end
      end
    end

    // R7: INTA edges while a vector is outstanding are dropped.
    arb_mode = 1'b0; ien = 1'b1; req = 4'b0001;
    inta = 1'b1;
    @(negedge clk);
    chk("R6 capture dev0", int'(vec), BASE);
    inta = 1'b0; req = 4'b0100;
    @(negedge clk);
    inta = 1'b1;
    @(negedge clk);
    chk("R7 edge ignored ack", int'(ack), 0);
    chk("R7 old vector kept", int'(vec), BASE);
    chk("R7 still valid", int'(vec_valid), 1);
    inta = 1'b0;
    @(negedge clk);
    // edge in the handshake cycle is also dropped
    inta = 1'b1; vec_ready = 1'b1;
    @(negedge clk);
    vec_ready = 1'b0;
    chk("R7 edge at handshake ack", int'(ack), 0);
    chk("R7 edge at handshake valid", int'(vec_valid), 0);
    inta = 1'b0;
    @(negedge clk);
    // a fresh edge now captures device 2
    inta = 1'b1;
    @(negedge clk);
    chk("R5 ack dev2", int'(ack), 4);
    chk("R6 vector dev2", int'(vec), BASE + 2);
    inta = 1'b0; vec_ready = 1'b1;
    @(negedge clk);
    vec_ready = 1'b0;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule